// File: doc/BRIEF.md
# Operand Effective Address Generator

This block forms the 16-bit effective address of a memory operand. The caller gives it an addressing form, the current contents of the four address registers, and a displacement. It returns the address and a flag that says the stack segment is the default. The two base registers are BX and BP, and the two index registers are SI and DI. The block only adds. The caller holds the registers, decodes the instruction and forms the physical address with a segment.

The caller gives four things:
- an addressing form: direct, single register, register plus displacement, or base plus index plus displacement;
- whether a base register takes part, and which one;
- whether an index register takes part, and which one;
- a displacement width.

A combination that the form does not allow raises an illegal flag and gives an address of zero. With the default parameter setting the results are registered, so they appear one clock after the request, together with a valid strobe. A parameter can remove the register, and then the same results follow the inputs in the same cycle.

Top module: `ea_gen`

## Requirements
- R1: Mode value 0 (direct) with both register enables low gives `ea` equal to the full 16-bit `disp`, for any `disp_size`, with `stack_seg` low.
- R2: Mode value 1 (single register) with exactly one enable high gives `ea` equal to the selected register, with the displacement ignored.
  - `base_sel` 0 selects BX and 1 selects BP.
  - `index_sel` 0 selects SI and 1 selects DI.
- R3: Mode value 2 (register plus displacement) with exactly one enable high gives `ea` equal to the selected register plus the extended displacement, modulo 2^16.
- R4: Mode value 3 (base plus index plus displacement) with both enables high gives `ea` equal to base plus index plus the extended displacement, modulo 2^16. This holds for all four pairings: BX+SI, BX+DI, BP+SI and BP+DI.
- R5: In modes 2 and 3, `disp_size` sets the extended displacement as follows:
  - 0: zero;
  - 1: `disp[7:0]` sign-extended, with `disp[15:8]` ignored;
  - 2: all 16 bits of `disp`;
  - 3: reserved, and makes the request illegal.
- R6: `stack_seg` is high exactly when a legal request in mode 1, 2 or 3 uses BP as its base. It is low for every other request.
- R7: `illegal` is high, `ea` is zero and `stack_seg` is low for any of these requests:
  - a mode value from 4 to 7;
  - register enables that do not match the mode;
  - `disp_size` 3 in mode 2 or 3.
- R8: With `REG_OUT`=1, the results of a request appear on the outputs one clock edge after it is presented. `out_valid` copies `in_valid` with the same one-cycle delay.
- R9: While `rst_n` is low, `out_valid`, `ea`, `stack_seg` and `illegal` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | The request inputs hold a request |
| mode | input | 3 | Addressing form (0 direct, 1 register, 2 register+disp, 3 base+index+disp) |
| base_en | input | 1 | A base register takes part |
| base_sel | input | 1 | Base choice: 0 BX, 1 BP |
| index_en | input | 1 | An index register takes part |
| index_sel | input | 1 | Index choice: 0 SI, 1 DI |
| disp_size | input | 2 | Displacement width: 0 none, 1 eight bits, 2 sixteen bits, 3 reserved |
| disp | input | 16 | Displacement, or the address field in direct mode |
| bx_val | input | 16 | Contents of BX |
| bp_val | input | 16 | Contents of BP |
| si_val | input | 16 | Contents of SI |
| di_val | input | 16 | Contents of DI |
| out_valid | output | 1 | The outputs hold the result of a request |
| ea | output | 16 | Effective address |
| stack_seg | output | 1 | The stack segment is the default |
| illegal | output | 1 | The request combination is not allowed |

## Verification
The assertions check these properties on every cycle:
- an illegal result always has a zero address;
- the stack flag never appears together with the illegal flag;
- the valid strobe follows its input by one cycle;
- a reserved mode value or a reserved width always produces the illegal flag;
- a direct request passes its address field through unchanged.

The bench scenarios cover the arithmetic:
- the sums in every pairing;
- wrap-around modulo 2^16;
- sign extension of negative 8-bit displacements;
- the rule that the displacement is ignored in single-register mode.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

    localparam int EA_W    = 16;
    localparam int SHORT_W = 8;

    typedef enum logic [2:0] {
        AM_DIRECT = 3'd0,
        AM_REG    = 3'd1,
        AM_REL    = 3'd2,
        AM_BIDX   = 3'd3
    } am_e;

    typedef enum logic [1:0] {
        DS_NONE  = 2'd0,
        DS_SHORT = 2'd1,
        DS_FULL  = 2'd2,
        DS_RSVD  = 2'd3
    } dsize_e;

    typedef struct packed {
        logic [EA_W-1:0] ea;
        logic            ss;
        logic            ill;
        logic            vld;
    } ea_out_t;

endpackage

// File: rtl/ea_disp_ext.sv
module ea_disp_ext
    import ea_gen_pkg::*;
#(
    parameter int W  = EA_W,
    parameter int SW = SHORT_W
) (
    input  logic [W-1:0] disp,
    input  logic [1:0]   size,
    output logic [W-1:0] ext,
    output logic         size_bad
);
    always_comb begin
        ext      = '0;
        size_bad = 1'b0;
        case (dsize_e'(size))
            DS_NONE:  ext = '0;
            DS_SHORT: ext = {{(W-SW){disp[SW-1]}}, disp[SW-1:0]};
            DS_FULL:  ext = disp;
            default:  size_bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/ea_reg_pick.sv
module ea_reg_pick
    import ea_gen_pkg::*;
#(
    parameter int W = EA_W
) (
    input  logic         base_sel,
    input  logic         index_sel,
    input  logic [W-1:0] bx_val,
    input  logic [W-1:0] bp_val,
    input  logic [W-1:0] si_val,
    input  logic [W-1:0] di_val,
    output logic [W-1:0] base_val,
    output logic [W-1:0] index_val
);
    always_comb begin
        base_val  = base_sel  ? bp_val : bx_val;
        index_val = index_sel ? di_val : si_val;
    end
endmodule

// File: rtl/ea_mode_ctl.sv
module ea_mode_ctl
    import ea_gen_pkg::*;
(
    input  logic [2:0] mode,
    input  logic       base_en,
    input  logic       index_en,
    input  logic       base_sel,
    input  logic       size_bad,
    output logic       use_base,
    output logic       use_index,
    output logic       use_disp,
    output logic       use_field,
    output logic       ill,
    output logic       ss
);
    logic one_reg;

    always_comb begin
        one_reg   = base_en ^ index_en;
        use_base  = 1'b0;
        use_index = 1'b0;
        use_disp  = 1'b0;
        use_field = 1'b0;
        ill       = 1'b0;
        case (am_e'(mode))
            AM_DIRECT: begin
                use_field = 1'b1;
                ill       = base_en | index_en;
            end
            AM_REG: begin
                use_base  = base_en;
                use_index = index_en;
                ill       = !one_reg;
            end
            AM_REL: begin
                use_base  = base_en;
                use_index = index_en;
                use_disp  = 1'b1;
                ill       = !one_reg | size_bad;
            end
            AM_BIDX: begin
                use_base  = 1'b1;
                use_index = 1'b1;
                use_disp  = 1'b1;
                ill       = !(base_en & index_en) | size_bad;
            end
            default: ill = 1'b1;
        endcase
        ss = use_base & base_sel & !ill;
    end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_gen_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [2:0]      mode,
    input  logic            base_en,
    input  logic            base_sel,
    input  logic            index_en,
    input  logic            index_sel,
    input  logic [1:0]      disp_size,
    input  logic [EA_W-1:0] disp,
    input  logic [EA_W-1:0] bx_val,
    input  logic [EA_W-1:0] bp_val,
    input  logic [EA_W-1:0] si_val,
    input  logic [EA_W-1:0] di_val,
    output logic            out_valid,
    output logic [EA_W-1:0] ea,
    output logic            stack_seg,
    output logic            illegal
);
    logic [EA_W-1:0] ext_d, base_v, index_v;
    logic            size_bad;
    logic            use_base, use_index, use_disp, use_field, ill, ss;
    logic [EA_W-1:0] sum;
    ea_out_t         out_d, out_q;

    ea_disp_ext #(.W(EA_W), .SW(SHORT_W)) u_ext (
        .disp     (disp),
        .size     (disp_size),
        .ext      (ext_d),
        .size_bad (size_bad)
    );

    ea_reg_pick #(.W(EA_W)) u_pick (
        .base_sel  (base_sel),
        .index_sel (index_sel),
        .bx_val    (bx_val),
        .bp_val    (bp_val),
        .si_val    (si_val),
        .di_val    (di_val),
        .base_val  (base_v),
        .index_val (index_v)
    );

    ea_mode_ctl u_ctl (
        .mode      (mode),
        .base_en   (base_en),
        .index_en  (index_en),
        .base_sel  (base_sel),
        .size_bad  (size_bad),
        .use_base  (use_base),
        .use_index (use_index),
        .use_disp  (use_disp),
        .use_field (use_field),
        .ill       (ill),
        .ss        (ss)
    );

    // Three-term sum; carries out of the top bit are dropped.
    always_comb begin
        sum = (use_base  ? base_v  : '0)
            + (use_index ? index_v : '0)
            + (use_disp  ? ext_d   : '0)
            + (use_field ? disp    : '0);
        out_d     = '0;
        out_d.ea  = ill ? '0 : sum;
        out_d.ss  = ss;
        out_d.ill = ill;
        out_d.vld = in_valid;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) out_q <= '0;
                else        out_q <= out_d;
            end
        end else begin : g_comb
            always_comb out_q = rst_n ? out_d : '0;
        end
    endgenerate

    assign ea        = out_q.ea;
    assign stack_seg = out_q.ss;
    assign illegal   = out_q.ill;
    assign out_valid = out_q.vld;
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk
    import ea_gen_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [2:0]      mode,
    input logic            base_en,
    input logic            index_en,
    input logic [1:0]      disp_size,
    input logic [EA_W-1:0] disp,
    input logic            out_valid,
    input logic [EA_W-1:0] ea,
    input logic            stack_seg,
    input logic            illegal
);
    AST_ILLEGAL_ZERO_EA: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (ea == '0));  // R7
    AST_SS_NOT_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        stack_seg |-> !illegal);  // R6

    generate
        if (REG_OUT) begin : g_seq
            AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);  // R8
            AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);  // R8
            AST_RSVD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
                mode[2] |=> illegal);  // R7
            AST_RSVD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
                ((mode == 3'd2 || mode == 3'd3) && disp_size == 2'd3) |=> illegal);  // R5
            AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
                (mode == 3'd0 && !base_en && !index_en) |=>
                    (ea == $past(disp) && !stack_seg));  // R1
        end
    endgenerate
endmodule

bind ea_gen ea_gen_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode      (mode),
    .base_en   (base_en),
    .index_en  (index_en),
    .disp_size (disp_size),
    .disp      (disp),
    .out_valid (out_valid),
    .ea        (ea),
    .stack_seg (stack_seg),
    .illegal   (illegal)
);

// File: tb/ea_gen_test.sv
module ea_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  mode = '0;
    logic        base_en = 1'b0, base_sel = 1'b0, index_en = 1'b0, index_sel = 1'b0;
    logic [1:0]  disp_size = '0;
    logic [15:0] disp = '0, bx_val = '0, bp_val = '0, si_val = '0, di_val = '0;
    logic        out_valid, stack_seg, illegal;
    logic [15:0] ea;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;  // 50 MHz

    ea_gen #(.REG_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .base_en(base_en), .base_sel(base_sel), .index_en(index_en),
        .index_sel(index_sel), .disp_size(disp_size), .disp(disp),
        .bx_val(bx_val), .bp_val(bp_val), .si_val(si_val), .di_val(di_val),
        .out_valid(out_valid), .ea(ea), .stack_seg(stack_seg), .illegal(illegal)
    );

    // Expected {illegal, stack_seg, ea}, built from the requirements.
    function automatic logic [17:0] model();
        logic        bad;
        logic [15:0] d, b, x, r;
        logic        one;
        bad = 1'b0;
        r   = '0;
        one = base_en ^ index_en;
        case (disp_size)
            2'd0:    d = 16'h0;
            2'd1:    d = {{8{disp[7]}}, disp[7:0]};
            2'd2:    d = disp;
            default: d = 16'h0;
        endcase
        b = base_sel  ? bp_val : bx_val;
        x = index_sel ? di_val : si_val;
        case (mode)
            3'd0: begin bad = base_en | index_en; r = disp; end
            3'd1: begin bad = !one; r = base_en ? b : x; end
            3'd2: begin bad = !one || disp_size == 2'd3; r = (base_en ? b : x) + d; end
            3'd3: begin bad = !(base_en && index_en) || disp_size == 2'd3; r = b + x + d; end
            default: bad = 1'b1;
        endcase
        if (bad) return {1'b1, 1'b0, 16'h0};
        return {1'b0, (mode != 3'd0) && base_en && base_sel, r};
    endfunction

    task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual ill=%0b ss=%0b ea=%h expected ill=%0b ss=%0b ea=%h",
                     tag, act[17], act[16], act[15:0], exp[17], exp[16], exp[15:0]);
        end
    endtask

    task automatic setreq(input logic [2:0] m, input logic be, input logic bs,
                          input logic ie, input logic is, input logic [1:0] ds,
                          input logic [15:0] dv);
        mode = m; base_en = be; base_sel = bs; index_en = ie; index_sel = is;
        disp_size = ds; disp = dv; in_valid = 1'b1;
    endtask

    // Inputs are set at a falling edge; the result is sampled one falling edge later (R8).
    task automatic run(input string tag);
        logic [17:0] exp;
        exp = model();
        @(negedge clk);
        check(tag, {illegal, stack_seg, ea}, exp);
        checks++;
        if (out_valid !== 1'b1) begin
            fails++;
            $display("FAIL R8: out_valid actual %0b expected 1", out_valid);
        end
    endtask

    function automatic string tag_of();
        if (mode > 3'd3) return "R7";
        case (mode)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            default: return "R4";
        endcase
    endfunction

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", {illegal, stack_seg, ea}, 18'h0);
        checks++;
        if (out_valid !== 1'b0) begin fails++; $display("FAIL R9: out_valid actual 1 expected 0"); end
        rst_n = 1'b1;
        bx_val = 16'h1000; bp_val = 16'h2000; si_val = 16'h0030; di_val = 16'h0400;

        setreq(3'd0, 0, 0, 0, 0, 2'd0, 16'h1234); run("R1");
        setreq(3'd1, 1, 0, 0, 0, 2'd2, 16'h5555); run("R2");
        setreq(3'd1, 1, 1, 0, 0, 2'd1, 16'h00FF); run("R6");
        setreq(3'd1, 0, 0, 1, 1, 2'd2, 16'h7777); run("R2");
        setreq(3'd2, 1, 1, 0, 0, 2'd1, 16'hAB80); run("R5");
        setreq(3'd2, 0, 0, 1, 0, 2'd0, 16'h4444); run("R5");
        bx_val = 16'hFFFF;
        setreq(3'd2, 1, 0, 0, 0, 2'd2, 16'h0002); run("R3");
        bx_val = 16'h1000;
        for (int p = 0; p < 4; p++) begin
            setreq(3'd3, 1, p[1], 1, p[0], 2'd1, 16'h00F0); run("R4");
        end
        setreq(3'd3, 1, 1, 1, 0, 2'd3, 16'h0001); run("R7");
        setreq(3'd5, 1, 1, 0, 0, 2'd2, 16'h0001); run("R7");
        setreq(3'd3, 1, 1, 0, 0, 2'd2, 16'h0001); run("R7");
        setreq(3'd0, 1, 1, 0, 0, 2'd2, 16'h0001); run("R7");

        // R8: a cycle with in_valid low gives out_valid low one edge later
        in_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin fails++; $display("FAIL R8: out_valid actual 1 expected 0"); end

        for (int i = 0; i < 3000; i++) begin
            logic [2:0] m;
            m = ($urandom % 10 == 0) ? 3'($urandom) : 3'($urandom % 4);
            bx_val = 16'($urandom); bp_val = 16'($urandom);
            si_val = 16'($urandom); di_val = 16'($urandom);
            setreq(m, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                   2'($urandom), 16'($urandom));
            if ($urandom % 4 != 0) begin
                if (m == 3'd3) begin base_en = 1; index_en = 1; end
                else if (m != 3'd0) index_en = !base_en;
                else begin base_en = 0; index_en = 0; end
                if (disp_size == 2'd3 && $urandom % 2 == 0) disp_size = 2'd1;
            end
            run(tag_of());
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule